// File: doc/BRIEF.md
# Strobe-Serviced Watchdog Timer

This block is a watchdog that a processor keeps quiet by pulling a strobe line from high to low often enough. It counts pulses of a slow timebase tick, and a two-bit select chooses one of three period lengths. The three settings correspond to a pin tied low, left floating or tied high. When a whole period passes without a valid strobe edge, the block raises a single-cycle timeout request, which goes to a separate reset generator. No input turns it off.

The strobe is asynchronous. It passes through a two-flop synchronizer, and an edge detector follows it. A reset-active input comes back from the reset generator. While that input is high, the block holds its counter at zero and ignores the strobe. The controller has three states. HOLD means reset is active and the counter is held at zero. COUNT means the counter is running. FIRE lasts one cycle and drives the timeout request. Its transitions are:
- HOLD→COUNT when reset-active falls.
- COUNT→FIRE on the tick that completes the period.
- FIRE→COUNT, with the counter reloaded to zero.
- Any state→HOLD while reset-active is high.

Top module: `strobe_watchdog`

## Requirements
- R1: During and right after rst_n, timeout_req is low. With no strobe activity, the first request arrives after a full period counted from the release.
- R2: With period_sel = 2'b00 (tied low), timeout_req pulses on the clock after the SHORT_TICKS-th tick.
- R3: With period_sel = 2'b01 (floating), the period is MID_TICKS ticks.
- R4: With period_sel = 2'b10 (tied high) or the unused code 2'b11, the period is LONG_TICKS ticks. The internal count never reaches LONG_TICKS.
- R5: timeout_req is high for exactly one clock. The count then reloads, so a second full period produces a second request.
- R6: A high-to-low edge on strobe_in restarts the period from zero. The restart takes effect within three clocks of the edge.
- R7: A low-to-high edge, or a strobe held at either level, does not restart the period.
- R8: While reset_active is high, there is no timeout request and strobe edges are ignored. Counting restarts from zero on the clock after reset_active falls.
- R9: The count advances only on cycles where tick is high. Clocks without a tick never bring a request closer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase pulse |
| period_sel | input | 2 | Period select: 00 short, 01 middle, 10/11 long |
| strobe_in | input | 1 | Asynchronous service strobe; a falling edge services the watchdog |
| reset_active | input | 1 | High while the downstream reset is asserted |
| timeout_req | output | 1 | One-clock request to the reset generator |

## Verification
The hardest case to reach is a falling strobe edge that occurs while reset_active is high and has already passed through the synchronizer when reset is released. A faulty design could store that edge and apply it late, silently shortening or lengthening the next period. The bench drops the strobe during reset, waits longer than the synchronizer delay, and then releases reset. It then counts ticks and expects the request on exactly the nominal tick. Services late in a period and pulses that arrive right after a request are placed tick by tick, so the bench can tell a reload apart from a late clear.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        WDG_HOLD  = 2'd0,
        WDG_COUNT = 2'd1,
        WDG_FIRE  = 2'd2
    } wdg_state_e;

    localparam logic [1:0] SEL_LOW   = 2'b00;
    localparam logic [1:0] SEL_FLOAT = 2'b01;
    localparam logic [1:0] SEL_HIGH  = 2'b10;
endpackage

// File: rtl/wdg_strobe_edge.sv
module wdg_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic strobe_fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Every stage resets to the idle-high level, so reset itself never looks like an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign strobe_fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/wdg_period_sel.sv
module wdg_period_sel #(
    parameter int SHORT_TICKS = 150,
    parameter int MID_TICKS   = 610,
    parameter int LONG_TICKS  = 1200,
    parameter int CW          = 11
) (
    input  logic [1:0]    period_sel,
    output logic [CW-1:0] last_count
);
    import wdg_pkg::*;

    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] MID_LAST   = CW'(MID_TICKS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

    always_comb begin
        unique case (period_sel)
            SEL_LOW:   last_count = SHORT_LAST;
            SEL_FLOAT: last_count = MID_LAST;
            SEL_HIGH:  last_count = LONG_LAST;
            default:   last_count = LONG_LAST;
        endcase
    end
endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          strobe_fall,
    input  logic          reset_active,
    input  logic [CW-1:0] last_count,
    output logic          timeout_req,
    output logic [CW-1:0] count_val
);
    import wdg_pkg::*;

    wdg_state_e    state_q, state_d;
    logic [CW-1:0] count_q, count_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WDG_HOLD;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            WDG_HOLD: begin
                count_d = '0;
                state_d = reset_active ? WDG_HOLD : WDG_COUNT;
            end
            WDG_COUNT: begin
                if (reset_active) begin
                    state_d = WDG_HOLD;
                    count_d = '0;
                end else if (strobe_fall) begin
                    count_d = '0;
                end else if (tick) begin
                    // A count already at or past the last value fires now, even if period_sel just shrank the period.
                    if (count_q >= last_count) begin
                        state_d = WDG_FIRE;
                        count_d = '0;
                    end else begin
                        count_d = count_q + 1'b1;
                    end
                end
            end
            WDG_FIRE: begin
                count_d = '0;
                state_d = reset_active ? WDG_HOLD : WDG_COUNT;
            end
            default: begin
                state_d = WDG_HOLD;
                count_d = '0;
            end
        endcase
    end

    always_comb begin
        timeout_req = (state_q == WDG_FIRE);
        count_val   = count_q;
    end
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
    parameter int SHORT_TICKS = 150,
    parameter int MID_TICKS   = 610,
    parameter int LONG_TICKS  = 1200,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] period_sel,
    input  logic       strobe_in,
    input  logic       reset_active,
    output logic       timeout_req
);
    localparam int CW = (LONG_TICKS > 2) ? $clog2(LONG_TICKS) : 1;

    logic          fall_w;
    logic [CW-1:0] last_w;
    logic [CW-1:0] count_w;

    wdg_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_in   (strobe_in),
        .strobe_fall (fall_w)
    );

    wdg_period_sel #(
        .SHORT_TICKS (SHORT_TICKS),
        .MID_TICKS   (MID_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .CW          (CW)
    ) u_sel (
        .period_sel (period_sel),
        .last_count (last_w)
    );

    wdg_fsm #(.CW(CW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .strobe_fall  (fall_w),
        .reset_active (reset_active),
        .last_count   (last_w),
        .timeout_req  (timeout_req),
        .count_val    (count_w)
    );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int CW         = 11,
    parameter int LONG_TICKS = 1200
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          reset_active,
    input logic          timeout_req,
    input logic          strobe_fall,
    input logic [CW-1:0] count_val
);
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_req |=> !timeout_req);

    p_quiet_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active |=> (!timeout_req && count_val == '0));

    p_fire_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_req) |-> $past(tick));

    p_edge_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_fall |=> (count_val == '0));

    p_count_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(count_val) < LONG_TICKS));
endmodule

bind strobe_watchdog wdg_checker #(.CW(CW), .LONG_TICKS(LONG_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .reset_active (reset_active),
    .timeout_req  (timeout_req),
    .strobe_fall  (fall_w),
    .count_val    (count_w)
);

// File: tb/strobe_watchdog_bench.sv
module strobe_watchdog_bench;
    localparam int T_S = 5, T_M = 9, T_L = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] period_sel = 2'b00;
    logic       strobe_in = 1'b1;
    logic       reset_active = 1'b0;
    logic       timeout_req;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    strobe_watchdog #(.SHORT_TICKS(T_S), .MID_TICKS(T_M), .LONG_TICKS(T_L)) u_strobe_watchdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period_sel(period_sel),
        .strobe_in(strobe_in), .reset_active(reset_active), .timeout_req(timeout_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: timeout_req=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One tick pulse. Sample just after the clock that consumed it, then one idle clock later.
    task automatic one_tick(input string req, input logic exp);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        check(req, timeout_req, exp);
        @(negedge clk);
        check(req, timeout_req, 1'b0);
    endtask

    task automatic expect_period(input int n, input string req);
        for (int i = 1; i <= n; i++) one_tick(req, i == n);
    endtask

    task automatic quiet_ticks(input int n, input string req);
        for (int i = 1; i <= n; i++) one_tick(req, 1'b0);
    endtask

    task automatic drive_strobe(input logic v);
        @(negedge clk) strobe_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_r1;
        repeat (3) @(negedge clk);
        check("R1", timeout_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", timeout_req, 1'b0);
        expect_period(T_S, "R1");
    endtask

    task automatic t_short_r2_r5;
        period_sel = 2'b00;
        expect_period(T_S, "R2");
        expect_period(T_S, "R5");
    endtask

    task automatic t_mid_r3;
        period_sel = 2'b01;
        expect_period(T_M, "R3");
    endtask

    task automatic t_long_r4;
        period_sel = 2'b10;
        expect_period(T_L, "R4");
        period_sel = 2'b11;
        expect_period(T_L, "R4");
    endtask

    task automatic t_fall_r6;
        period_sel = 2'b00;
        quiet_ticks(T_S - 1, "R6");
        drive_strobe(1'b0);
        expect_period(T_S, "R6");
    endtask

    task automatic t_static_r7;
        quiet_ticks(2, "R7");
        drive_strobe(1'b1);
        expect_period(T_S - 2, "R7");
        quiet_ticks(T_S - 1, "R7");
        one_tick("R7", 1'b1);
    endtask

    task automatic t_reset_active_r8;
        quiet_ticks(2, "R8");
        @(negedge clk) reset_active = 1'b1;
        quiet_ticks(2 * T_L, "R8");
        drive_strobe(1'b0);
        drive_strobe(1'b1);
        @(negedge clk) strobe_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", timeout_req, 1'b0);
        reset_active = 1'b0;
        @(negedge clk);
        expect_period(T_S, "R8");
    endtask

    task automatic t_tick_only_r9;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check("R9", timeout_req, 1'b0);
        end
        expect_period(T_S, "R9");
    endtask

    initial begin
        t_reset_r1();
        t_short_r2_r5();
        t_mid_r3();
        t_long_r4();
        t_fall_r6();
        t_static_r7();
        t_reset_active_r8();
        t_tick_only_r9();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: bench did not complete");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule